// File: doc/BRIEF.md
# External Program Memory Strobe Generator

This block drives the active-low read strobe for instruction fetches from off-chip code memory in an 8051-style bus. A free-running phase counter splits the oscillator clock into machine cycles of 12 clocks in standard mode or 6 clocks in the double-speed mode. In a machine cycle that fetches from off-chip memory, the strobe goes low twice. The first pulse starts at the first quarter of the cycle and the second at the third quarter.

At the start of every machine cycle the block samples four things: the speed mode, a flag that marks the cycle as an off-chip data access, the fetch address and the active-low access-select pin. From these it decides whether the fetch is internal or external. That decision is held on an output for the whole cycle. Both strobe pulses are dropped in a data-access cycle and in any internal fetch. A lock input stands for the programmed security level. When the lock is set, the decision uses the pin value captured on the last reset clock, and later pin changes have no effect.

Top module: `xcode_strobe_gen`

## Requirements
- R1: While reset is asserted (synchronous, active low), `strobe_no` is 1 and `fetch_ext_o` is 0 after the next clock edge. The first clock edge with reset released starts machine cycle phase 0.
- R2: In standard mode a machine cycle is 12 clocks, phases 0 to 11. In an active cycle `strobe_no` is 0 during phases 0-2 and 6-8 and 1 in all other phases.
- R3: In double-speed mode (`turbo_i`=1) a machine cycle is 6 clocks. In an active cycle `strobe_no` is 0 during phases 0 and 3 only. The mode is sampled at the clock edge that starts a cycle.
- R4: If `xdata_cyc_i` is 1 at the edge that starts a cycle, `strobe_no` stays 1 for that whole cycle.
- R5: When the decision for a cycle is internal (`fetch_ext_o`=0), `strobe_no` stays 1 for that whole cycle.
- R6: The fetch is external when the effective access pin is 0, or when `fetch_addr_i` is 0x8000 or above. It is internal otherwise. The decision is sampled at the cycle-start edge and held on `fetch_ext_o` until the next cycle-start edge.
- R7: With `pin_lock_i`=1, the effective access pin is the `xacc_ni` value seen at the last clock edge of reset, and later pin changes are ignored. With `pin_lock_i`=0, the live pin value is used at each cycle start.
- R8: An active cycle holds exactly two falling edges of `strobe_no`. Any other cycle holds none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| turbo_i | input | 1 | 1 selects 6 clocks per machine cycle, 0 selects 12 |
| xdata_cyc_i | input | 1 | Marks the starting machine cycle as an off-chip data access |
| fetch_addr_i | input | 16 | Program counter fetch address |
| xacc_ni | input | 1 | Access-select pin, low forces every fetch off-chip |
| pin_lock_i | input | 1 | Security lock: freeze the access pin at reset |
| strobe_no | output | 1 | Active-low program fetch strobe |
| fetch_ext_o | output | 1 | 1 when the current cycle fetches off-chip |

## Verification
The hardest case to reach from the ports is a locked pin that changes after reset. It only shows when the pin captured during reset and the live pin disagree, and the address sits below the internal limit. The stimulus first resets with the lock set and the pin at each level. It then toggles the pin at random while holding addresses under 0x8000, so any use of the live pin changes the decision. Random mode and data-flag changes land in the middle of cycles. These changes show that only values present at a cycle-start edge matter. Addresses are weighted toward 0x7FFF and 0x8000.

// File: rtl/xcs_pkg.sv
package xcs_pkg;

   typedef enum logic {
      CYC_STD = 1'b0,
      CYC_X2  = 1'b1
   } cyc_mode_e;

   // length of one strobe pulse in clocks
   function automatic int quarter_len(input int clocks);
      return clocks / 4;
   endfunction

   // phase at which the second pulse starts
   function automatic int half_len(input int clocks);
      return clocks / 2;
   endfunction

endpackage

// File: rtl/xcs_phase_ctr.sv
module xcs_phase_ctr
   import xcs_pkg::*;
#(
   parameter int CLK_STD = 12,
   parameter int CLK_X2  = 6,
   parameter int PH_W    = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            turbo_i,
   output logic            start_o,
   output logic [PH_W-1:0] phase_n_o,
   output cyc_mode_e       mode_n_o
);

   localparam logic [PH_W-1:0] LAST_STD = PH_W'(CLK_STD - 1);
   localparam logic [PH_W-1:0] LAST_X2  = PH_W'(CLK_X2 - 1);

   logic [PH_W-1:0] phase_q;
   cyc_mode_e       mode_q;
   logic [PH_W-1:0] last_ph;

   always_comb begin
      last_ph   = (mode_q == CYC_X2) ? LAST_X2 : LAST_STD;
      start_o   = (phase_q == last_ph);
      phase_n_o = start_o ? '0 : phase_q + 1'b1;
      if (start_o) begin
         mode_n_o = turbo_i ? CYC_X2 : CYC_STD;
      end else begin
         mode_n_o = mode_q;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         phase_q <= LAST_STD;
         mode_q  <= CYC_STD;
      end else begin
         phase_q <= phase_n_o;
         mode_q  <= mode_n_o;
      end
   end

   // R2: a standard cycle advances one phase per clock until its last phase
   assert_std_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == CYC_STD && phase_q != LAST_STD) |=> (phase_q == $past(phase_q) + 1'b1))
      else $error("standard phase did not advance");

   // R3: a double-speed cycle never leaves its six phases
   assert_x2_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == CYC_X2) |-> (phase_q <= LAST_X2))
      else $error("double-speed phase out of range");

endmodule

// File: rtl/xcs_fetch_decode.sv
module xcs_fetch_decode #(
   parameter int ADDR_W       = 16,
   parameter int INT_BYTES    = 32768,
   parameter bit HAS_PIN_LOCK = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              lock_i,
   input  logic              xacc_ni,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              ext_o
);

   localparam int              CMP_W   = ADDR_W + 1;
   localparam logic [CMP_W-1:0] INT_TOP = CMP_W'(INT_BYTES);

   logic above_int;
   logic acc_eff_n;

   assign above_int = ({1'b0, addr_i} >= INT_TOP);

   generate
      if (HAS_PIN_LOCK) begin : g_lock
         logic pin_held;

         // loads only while reset is applied: last reset clock wins
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               pin_held <= xacc_ni;
            end
         end

         assign acc_eff_n = lock_i ? pin_held : xacc_ni;

         // R7: under lock the decision does not follow the live pin
         assert_lock_ignores_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(rst_ni) && lock_i && $stable(lock_i) && $stable(addr_i)) |-> $stable(ext_o))
            else $error("locked decision moved with the pin");
      end else begin : g_free
         assign acc_eff_n = xacc_ni;
      end
   endgenerate

   assign ext_o = !acc_eff_n || above_int;

   // R6: a low live pin without lock always means off-chip
   assert_low_pin_ext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!xacc_ni && !lock_i) |-> ext_o)
      else $error("low pin gave internal fetch");

endmodule

// File: rtl/xcs_strobe_shaper.sv
module xcs_strobe_shaper
   import xcs_pkg::*;
#(
   parameter int CLK_STD = 12,
   parameter int CLK_X2  = 6,
   parameter int PH_W    = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            start_i,
   input  logic [PH_W-1:0] phase_n_i,
   input  cyc_mode_e       mode_n_i,
   input  logic            data_i,
   input  logic            ext_i,
   output logic            strobe_no,
   output logic            ext_o
);

   localparam logic [PH_W-1:0] Q_STD  = PH_W'(quarter_len(CLK_STD));
   localparam logic [PH_W-1:0] H_STD  = PH_W'(half_len(CLK_STD));
   localparam logic [PH_W-1:0] HQ_STD = PH_W'(half_len(CLK_STD) + quarter_len(CLK_STD));
   localparam logic [PH_W-1:0] Q_X2   = PH_W'(quarter_len(CLK_X2));
   localparam logic [PH_W-1:0] H_X2   = PH_W'(half_len(CLK_X2));
   localparam logic [PH_W-1:0] HQ_X2  = PH_W'(half_len(CLK_X2) + quarter_len(CLK_X2));

   logic            data_q, ext_q, strobe_q;
   logic            data_n, ext_n, strobe_d;
   logic [PH_W-1:0] q_end, h_beg, h_end;
   logic            in_pulse;

   always_comb begin
      if (mode_n_i == CYC_X2) begin
         q_end = Q_X2;
         h_beg = H_X2;
         h_end = HQ_X2;
      end else begin
         q_end = Q_STD;
         h_beg = H_STD;
         h_end = HQ_STD;
      end
      in_pulse = (phase_n_i < q_end) || ((phase_n_i >= h_beg) && (phase_n_i < h_end));
      data_n   = start_i ? data_i : data_q;
      ext_n    = start_i ? ext_i  : ext_q;
      strobe_d = !(in_pulse && ext_n && !data_n);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         data_q   <= 1'b0;
         ext_q    <= 1'b0;
         strobe_q <= 1'b1;
      end else begin
         data_q   <= data_n;
         ext_q    <= ext_n;
         strobe_q <= strobe_d;
      end
   end

   assign strobe_no = strobe_q;
   assign ext_o     = ext_q;

   // checker: falling strobe edges within the current machine cycle
   logic       fall_now;
   logic [1:0] fall_cnt;

   assign fall_now = strobe_q && !strobe_d;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         fall_cnt <= 2'd0;
      end else if (start_i) begin
         fall_cnt <= {1'b0, fall_now};
      end else if (fall_now && fall_cnt != 2'd3) begin
         fall_cnt <= fall_cnt + 2'd1;
      end
   end

   // R1: reset forces the strobe high and the decision internal
   assert_reset_idle_R1: assert property (@(posedge clk_i)
      !rst_ni |=> (strobe_q && !ext_q))
      else $error("strobe not idle after reset");

   // R4: data-access cycles keep the strobe high
   assert_data_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      data_q |-> strobe_q)
      else $error("strobe low in a data cycle");

   // R5: internal fetch cycles keep the strobe high
   assert_int_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ext_q |-> strobe_q)
      else $error("strobe low on an internal fetch");

   // R8: an active cycle ends with exactly two falling edges
   assert_two_pulses_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && ext_q && !data_q) |-> (fall_cnt == 2'd2))
      else $error("active cycle without two strobe pulses");

   // R8: a suppressed cycle ends with none
   assert_no_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && (!ext_q || data_q)) |-> (fall_cnt == 2'd0))
      else $error("suppressed cycle produced a pulse");

endmodule

// File: rtl/xcode_strobe_gen.sv
module xcode_strobe_gen
   import xcs_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int INT_BYTES    = 32768,
   parameter int CLK_STD      = 12,
   parameter int CLK_X2       = 6,
   parameter bit HAS_PIN_LOCK = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              turbo_i,
   input  logic              xdata_cyc_i,
   input  logic [ADDR_W-1:0] fetch_addr_i,
   input  logic              xacc_ni,
   input  logic              pin_lock_i,
   output logic              strobe_no,
   output logic              fetch_ext_o
);

   localparam int PH_W = $clog2(CLK_STD);

   generate
      if (CLK_STD < 4 || (CLK_STD % 2) != 0) begin : g_bad_std
         $error("CLK_STD must be even and at least 4");
      end
      if (CLK_X2 < 4 || (CLK_X2 % 2) != 0 || CLK_X2 > CLK_STD) begin : g_bad_x2
         $error("CLK_X2 must be even, at least 4 and not above CLK_STD");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W must lie between 8 and 32");
      end
      if (INT_BYTES < 1 || INT_BYTES > (1 << ADDR_W)) begin : g_bad_int
         $error("INT_BYTES must fit the address space");
      end
   endgenerate

   logic            cyc_start;
   logic [PH_W-1:0] phase_n;
   cyc_mode_e       mode_n;
   logic            ext_dec;

   xcs_phase_ctr #(
      .CLK_STD (CLK_STD),
      .CLK_X2  (CLK_X2),
      .PH_W    (PH_W)
   ) u_phase (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .turbo_i   (turbo_i),
      .start_o   (cyc_start),
      .phase_n_o (phase_n),
      .mode_n_o  (mode_n)
   );

   xcs_fetch_decode #(
      .ADDR_W       (ADDR_W),
      .INT_BYTES    (INT_BYTES),
      .HAS_PIN_LOCK (HAS_PIN_LOCK)
   ) u_decode (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lock_i  (pin_lock_i),
      .xacc_ni (xacc_ni),
      .addr_i  (fetch_addr_i),
      .ext_o   (ext_dec)
   );

   xcs_strobe_shaper #(
      .CLK_STD (CLK_STD),
      .CLK_X2  (CLK_X2),
      .PH_W    (PH_W)
   ) u_shaper (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (cyc_start),
      .phase_n_i (phase_n),
      .mode_n_i  (mode_n),
      .data_i    (xdata_cyc_i),
      .ext_i     (ext_dec),
      .strobe_no (strobe_no),
      .ext_o     (fetch_ext_o)
   );

endmodule

// File: tb/xcode_strobe_gen_test.sv
module xcode_strobe_gen_test;

   localparam int ADDR_W  = 16;
   localparam int LIMIT   = 32768;
   localparam int WD_CYC  = 150000;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              turbo, xdata, xacc_n, lock;
   logic [ADDR_W-1:0] addr;
   logic              strobe_n, fetch_ext;

   always #10 clk = ~clk;

   xcode_strobe_gen uut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .turbo_i      (turbo),
      .xdata_cyc_i  (xdata),
      .fetch_addr_i (addr),
      .xacc_ni      (xacc_n),
      .pin_lock_i   (lock),
      .strobe_no    (strobe_n),
      .fetch_ext_o  (fetch_ext)
   );

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   // cycle model built from the requirements
   bit  m_valid = 1'b0;
   bit  m_in_rst, m_turbo, m_data, m_ext, m_lat;
   int  m_phase;

   function automatic int cyc_len(input bit t);
      return t ? 6 : 12;
   endfunction

   function automatic bit in_pulse(input int p, input bit t);
      int q = cyc_len(t) / 4;
      int h = cyc_len(t) / 2;
      return (p < q) || (p >= h && p < h + q);
   endfunction

   function automatic bit want_ext(input bit lk, input bit held, input bit pin,
                                   input logic [ADDR_W-1:0] a);
      bit eff = lk ? held : pin;
      return !eff || (int'(a) >= LIMIT);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid  <= 1'b1;
         m_in_rst <= 1'b1;
         m_phase  <= 11;
         m_turbo  <= 1'b0;
         m_data   <= 1'b0;
         m_ext    <= 1'b0;
         m_lat    <= xacc_n;
      end else if (m_valid) begin
         m_in_rst <= 1'b0;
         if (m_phase == cyc_len(m_turbo) - 1) begin
            m_phase <= 0;
            m_turbo <= turbo;
            m_data  <= xdata;
            m_ext   <= want_ext(lock, m_lat, xacc_n, addr);
         end else begin
            m_phase <= m_phase + 1;
         end
      end
   end

   task automatic check(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (m_valid) begin
         string ts, tf;
         bit es;
         if (m_in_rst) ts = "R1";
         else if (m_data && m_ext) ts = "R4";
         else if (!m_ext) ts = "R5";
         else if (m_turbo) ts = "R3";
         else ts = "R2";
         if (m_in_rst) tf = "R1";
         else if (lock) tf = "R7";
         else tf = "R6";
         es = !(in_pulse(m_phase, m_turbo) && m_ext && !m_data);
         check(ts, "strobe_no", strobe_n, es);
         check(tf, "fetch_ext_o", fetch_ext, m_ext);
      end
   endtask

   task automatic apply_reset(input bit lk, input bit pin);
      rst_n  = 1'b0;
      lock   = lk;
      xacc_n = pin;
      repeat (3) tick();
      rst_n = 1'b1;
   endtask

   function automatic logic [ADDR_W-1:0] pick_addr(input bit low_only);
      int sel = $urandom_range(0, 5);
      logic [ADDR_W-1:0] a;
      case (sel)
         0: a = 16'h7FFF;
         1: a = 16'h8000;
         2: a = 16'hFFFF;
         3: a = 16'h0000;
         default: a = ADDR_W'($urandom);
      endcase
      if (low_only) a[ADDR_W-1] = 1'b0;
      return a;
   endfunction

   // wait until the model sits at the last phase, so the next edge starts a cycle
   task automatic to_cycle_end();
      while (!(m_phase == cyc_len(m_turbo) - 1 && !m_in_rst)) tick();
   endtask

   task automatic count_pulses(input bit t, input string tag, input int lows_exp);
      int lows = 0;
      int falls = 0;
      logic prev;
      turbo = t; xdata = 1'b0; xacc_n = 1'b0;
      to_cycle_end();
      prev = strobe_n;
      for (int i = 0; i < cyc_len(t); i++) begin
         tick();
         if (!strobe_n) lows++;
         if (prev && !strobe_n) falls++;
         prev = strobe_n;
      end
      n_chk++;
      if (falls != 2) begin
         n_bad++;
         $display("FAIL R8 falling edges: actual %0d expected 2", falls);
      end
      n_chk++;
      if (lows != lows_exp) begin
         n_bad++;
         $display("FAIL %s low clocks: actual %0d expected %0d", tag, lows, lows_exp);
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; turbo = 1'b0; xdata = 1'b0; xacc_n = 1'b1; lock = 1'b0; addr = '0;

      // R1: idle during reset
      apply_reset(1'b0, 1'b1);

      // R8, R2, R3: directed pulse shapes
      count_pulses(1'b0, "R2", 6);
      count_pulses(1'b1, "R3", 2);

      // R6: address boundary with pin high
      xacc_n = 1'b1; xdata = 1'b0; turbo = 1'b0; addr = 16'h7FFF;
      to_cycle_end(); tick(); tick();
      check("R6", "fetch_ext_o at 0x7FFF", fetch_ext, 1'b0);
      addr = 16'h8000;
      to_cycle_end(); tick(); tick();
      check("R6", "fetch_ext_o at 0x8000", fetch_ext, 1'b1);
      check("R2", "strobe_no phase 1", strobe_n, 1'b0);

      // R4: data flag raised mid-cycle only counts at the next start
      xdata = 1'b1;
      to_cycle_end(); tick();
      check("R4", "strobe_no in data cycle", strobe_n, 1'b1);

      // random, lock off
      for (int i = 0; i < 6000; i++) begin
         tick();
         turbo  = ($urandom_range(0, 3) == 0);
         xdata  = ($urandom_range(0, 4) == 0);
         xacc_n = ($urandom_range(0, 2) != 0);
         addr   = pick_addr(1'b0);
      end

      // R7: lock with pin captured low, live pin toggles, low addresses
      apply_reset(1'b1, 1'b0);
      for (int i = 0; i < 3000; i++) begin
         tick();
         xacc_n = $urandom_range(0, 1);
         xdata  = ($urandom_range(0, 5) == 0);
         turbo  = $urandom_range(0, 1);
         addr   = pick_addr(1'b1);
      end
      xacc_n = 1'b1; addr = 16'h0100; xdata = 1'b0;
      to_cycle_end(); tick();
      check("R7", "fetch_ext_o locked low pin", fetch_ext, 1'b1);

      // R7: lock with pin captured high
      apply_reset(1'b1, 1'b1);
      for (int i = 0; i < 3000; i++) begin
         tick();
         xacc_n = $urandom_range(0, 1);
         xdata  = ($urandom_range(0, 5) == 0);
         turbo  = $urandom_range(0, 1);
         addr   = pick_addr(1'b1);
      end
      xacc_n = 1'b0; addr = 16'h0100; xdata = 1'b0;
      to_cycle_end(); tick();
      check("R7", "fetch_ext_o locked high pin", fetch_ext, 1'b0);

      // R7: lock off again, live pin low forces external
      apply_reset(1'b0, 1'b1);
      xacc_n = 1'b0; addr = 16'h0100;
      to_cycle_end(); tick();
      check("R7", "fetch_ext_o live pin", fetch_ext, 1'b1);

      // R1: reset mid-cycle returns to idle
      for (int i = 0; i < 5; i++) tick();
      rst_n = 1'b0;
      tick(); tick();
      check("R1", "strobe_no in reset", strobe_n, 1'b1);
      check("R1", "fetch_ext_o in reset", fetch_ext, 1'b0);
      rst_n = 1'b1;
      for (int i = 0; i < 40; i++) tick();

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule